// File: doc/BRIEF.md
# Keyed Slow-Clock Source Selector

This block picks the source of the slow timekeeping clock and turns it into a tick enable for the system clock domain. Two candidate sources arrive as one-cycle enables: a fast internal RC path and an external crystal path. On the RC path the enable is first divided by a fixed factor, then by a programmable factor of (P+1). The crystal path passes straight through. The result is a single-cycle `slow_tick`. A second output carries the same tick when the output gate is open.

Software controls the block through a small register window on the system clock. The control word holds the source select. A write to it is accepted only when its upper half carries the unlock key 0x16AA. Otherwise the word is left alone. The control word also shows three read-only busy flags supplied from outside. Whenever the source or the prescaler value actually changes, both divider stages restart from zero. The first tick after a change therefore comes a full period later.

Top module: `lsclk_selector`

## Requirements
- R1: After reset the source is the RC path (0), the prescaler is 0 and the gate is closed. `slow_tick`, `slow_tick_gated` and `src_is_xtal` are low. Only the busy bits of the control word read non-zero.
- R2: A write to offset 0x00 changes the source bit only when bits [31:16] of the write data equal 0x16AA. Any other key value leaves the control word unchanged.
- R3: Offset 0x00 reads the source at bit 0 and `busy_in` at bits [9:7]. All other bits, including the key field [31:16], read zero. A keyed write cannot alter bits [9:7].
- R4: With source bit 1 (crystal), every cycle with `xtal_tick_en` high gives `slow_tick` high in the next cycle, with no division. `rc_tick_en` has no effect in this mode.
- R5: With source bit 0 (RC), `slow_tick` pulses once for every FIX_DIV*(P+1) cycles with `rc_tick_en` high. The pulse comes in the cycle after the completing enable. P is bits [4:0] of offset 0x08, which reads back P in [4:0] and zero above.
- R6: Bit 0 of offset 0x60 opens the gate. `slow_tick_gated` equals `slow_tick` while the gate is open and stays low while it is closed.
- R7: A write that changes the source or the prescaler value clears both dividers. Any source enable in that write cycle is dropped, and `slow_tick` is low in the following cycle. Rewriting the same prescaler value leaves the count running.
- R8: `src_is_xtal` always equals control bit 0.
- R9: Reads of any other offset return zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| busy_in | input | 3 | Busy flags shown in control bits [9:7] |
| rc_tick_en | input | 1 | One-cycle enable from the internal RC oscillator |
| xtal_tick_en | input | 1 | One-cycle enable from the external crystal |
| src_is_xtal | output | 1 | High when the crystal path is selected |
| slow_tick | output | 1 | One-cycle slow clock enable |
| slow_tick_gated | output | 1 | `slow_tick` qualified by the output gate |

## Verification
A stale or mis-sized divider count shows up as a tick one or more enables early or late, and it shows within a single period. The largest period in the reduced configuration is 128 RC enables. The bench models the count arithmetically and compares the tick every cycle. That way the first wrong edge is caught, not just the average rate. A key check that is too lax shows in the very next cycle on `src_is_xtal`. A missing divider clear after a configuration change shows as a tick before the full new period has elapsed.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;

    localparam int DATA_W  = 32;
    localparam int PRESC_W = 5;
    localparam int BUSY_W  = 3;
    localparam int BUSY_LSB = 7;

    localparam logic [15:0] UNLOCK_KEY = 16'h16AA;

    // register offsets (12-bit window; ADDR_W must not exceed 12)
    localparam logic [11:0] OFS_CTRL  = 12'h000;
    localparam logic [11:0] OFS_PRESC = 12'h008;
    localparam logic [11:0] OFS_GATE  = 12'h060;

    typedef enum logic {
        SRC_RC   = 1'b0,
        SRC_XTAL = 1'b1
    } lsclk_src_e;

    typedef struct packed {
        lsclk_src_e           src;
        logic [PRESC_W-1:0]   presc;
        logic                 gate;
    } lsclk_cfg_t;

    localparam lsclk_cfg_t CFG_RESET = '{src: SRC_RC, presc: '0, gate: 1'b0};

    function automatic logic key_ok(input logic [DATA_W-1:0] w);
        return w[DATA_W-1:DATA_W-16] == UNLOCK_KEY;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input lsclk_src_e s,
                                                     input logic [BUSY_W-1:0] b);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = s;
        w[BUSY_LSB +: BUSY_W] = b;
        return w;
    endfunction

endpackage

// File: rtl/lsclk_regs.sv
module lsclk_regs
    import lsclk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [BUSY_W-1:0]    busy_in,
    output logic [DATA_W-1:0]    reg_rdata,
    output lsclk_cfg_t           cfg,
    output logic                 cfg_change
);

    logic [11:0] a12;
    logic hit_ctrl, hit_presc, hit_gate;
    logic src_wr, presc_wr, gate_wr;
    lsclk_cfg_t cfg_q;
    logic unused_wbits;

    assign a12 = 12'(reg_addr);
    assign unused_wbits = ^{reg_wdata[15:PRESC_W]};

    always_comb begin
        hit_ctrl  = (a12 == OFS_CTRL);
        hit_presc = (a12 == OFS_PRESC);
        hit_gate  = (a12 == OFS_GATE);
        src_wr    = reg_we && hit_ctrl && key_ok(reg_wdata);
        presc_wr  = reg_we && hit_presc;
        gate_wr   = reg_we && hit_gate;
        cfg_change = (src_wr && (reg_wdata[0] != cfg_q.src)) ||
                     (presc_wr && (reg_wdata[PRESC_W-1:0] != cfg_q.presc));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else begin
            if (src_wr)   cfg_q.src   <= lsclk_src_e'(reg_wdata[0]);
            if (presc_wr) cfg_q.presc <= reg_wdata[PRESC_W-1:0];
            if (gate_wr)  cfg_q.gate  <= reg_wdata[0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl)
            reg_rdata = ctrl_word(cfg_q.src, busy_in);
        else if (hit_presc)
            reg_rdata[PRESC_W-1:0] = cfg_q.presc;
        else if (hit_gate)
            reg_rdata[0] = cfg_q.gate;
    end

    assign cfg = cfg_q;

    AST_KEY_GUARD: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (12'(reg_addr) == OFS_CTRL) && (reg_wdata[31:16] != UNLOCK_KEY))
        |=> $stable(cfg_q.src)); // R2

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (12'(reg_addr) != OFS_CTRL) && (12'(reg_addr) != OFS_PRESC) &&
         (12'(reg_addr) != OFS_GATE))
        |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/lsclk_div_stage.sv
module lsclk_div_stage #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             pulse_in,
    input  logic [CNT_W-1:0] limit,
    output logic             pulse_out
);

    logic [CNT_W-1:0] cnt;
    logic at_end;

    assign at_end    = (cnt == limit);
    assign pulse_out = pulse_in && at_end && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (pulse_in)
            cnt <= at_end ? '0 : cnt + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit); // R5

endmodule

// File: rtl/lsclk_tick_out.sv
module lsclk_tick_out
    import lsclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  lsclk_src_e src,
    input  logic       rc_div_pulse,
    input  logic       xtal_en,
    input  logic       gate,
    output logic       tick,
    output logic       tick_gated
);

    logic sel_pulse;

    always_comb begin
        unique case (src)
            SRC_XTAL: sel_pulse = xtal_en;
            default:  sel_pulse = rc_div_pulse;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tick       <= 1'b0;
            tick_gated <= 1'b0;
        end else begin
            tick       <= sel_pulse;
            tick_gated <= sel_pulse && gate;
        end
    end

    AST_GATE_SUBSET: assert property (@(posedge clk) disable iff (rst)
        tick_gated |-> tick); // R6

    AST_XTAL_PASS: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(src == SRC_XTAL)) |-> $past(xtal_en)); // R4

endmodule

// File: rtl/lsclk_selector.sv
module lsclk_selector
    import lsclk_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int FIX_DIV = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [2:0]        busy_in,
    input  logic              rc_tick_en,
    input  logic              xtal_tick_en,
    output logic              src_is_xtal,
    output logic              slow_tick,
    output logic              slow_tick_gated
);

    localparam int FIX_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

    lsclk_cfg_t cfg;
    logic cfg_change;
    logic rc_in, rc_fixed, rc_div;

    lsclk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .busy_in    (busy_in),
        .reg_rdata  (reg_rdata),
        .cfg        (cfg),
        .cfg_change (cfg_change)
    );

    // RC enables only advance the dividers while the RC path is selected
    assign rc_in = rc_tick_en && (cfg.src == SRC_RC);

    generate
        if (FIX_DIV > 1) begin : g_fixed
            lsclk_div_stage #(.CNT_W(FIX_W)) u_fixed (
                .clk       (clk),
                .rst       (rst),
                .clr       (cfg_change),
                .pulse_in  (rc_in),
                .limit     (FIX_W'(FIX_DIV - 1)),
                .pulse_out (rc_fixed)
            );
        end else begin : g_nofixed
            assign rc_fixed = rc_in && !cfg_change;
        end
    endgenerate

    lsclk_div_stage #(.CNT_W(PRESC_W)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .clr       (cfg_change),
        .pulse_in  (rc_fixed),
        .limit     (cfg.presc),
        .pulse_out (rc_div)
    );

    lsclk_tick_out u_tick (
        .clk          (clk),
        .rst          (rst),
        .clr          (cfg_change),
        .src          (cfg.src),
        .rc_div_pulse (rc_div),
        .xtal_en      (xtal_tick_en),
        .gate         (cfg.gate),
        .tick         (slow_tick),
        .tick_gated   (slow_tick_gated)
    );

    assign src_is_xtal = (cfg.src == SRC_XTAL);

    AST_SWITCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (src_is_xtal != $past(src_is_xtal)) |-> !slow_tick); // R7

endmodule

// File: tb/test_lsclk_selector.sv
module test_lsclk_selector;

    localparam int FIX = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  busy_in = '0;
    logic        rc_tick_en = 1'b0;
    logic        xtal_tick_en = 1'b0;
    logic        src_is_xtal, slow_tick, slow_tick_gated;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic       m_src = 1'b0;
    logic [4:0] m_presc = '0;
    logic       m_gate = 1'b0;
    int         m_cnt = 0;

    always #2.5 clk = ~clk;

    lsclk_selector #(.ADDR_W(8), .FIX_DIV(FIX)) i_lsclk_selector (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_in(busy_in),
        .rc_tick_en(rc_tick_en), .xtal_tick_en(xtal_tick_en),
        .src_is_xtal(src_is_xtal), .slow_tick(slow_tick),
        .slow_tick_gated(slow_tick_gated)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                         input logic iv, input logic xv, input string tag);
        logic chg, exp_t, exp_g;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        rc_tick_en = iv; xtal_tick_en = xv;
        chg = we && ((a == 8'h00 && d[31:16] == 16'h16AA && d[0] != m_src) ||
                     (a == 8'h08 && d[4:0] != m_presc));
        exp_t = 1'b0;
        if (chg) m_cnt = 0;
        else if (m_src) exp_t = xv;
        else if (iv) begin
            m_cnt++;
            if (m_cnt == FIX * (int'(m_presc) + 1)) begin
                exp_t = 1'b1;
                m_cnt = 0;
            end
        end
        exp_g = exp_t & m_gate;
        if (we) begin
            if (a == 8'h00 && d[31:16] == 16'h16AA) m_src = d[0];
            if (a == 8'h08) m_presc = d[4:0];
            if (a == 8'h60) m_gate = d[0];
        end
        @(posedge clk);
        #1;
        check(tag, {31'b0, slow_tick}, {31'b0, exp_t});
        check("R6", {31'b0, slow_tick_gated}, {31'b0, exp_g});
        check("R8", {31'b0, src_is_xtal}, {31'b0, m_src});
        reg_we = 1'b0; rc_tick_en = 1'b0; xtal_tick_en = 1'b0;
    endtask

    task automatic idle_pulses(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(1'b0, 8'h10, 32'h0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check("R1", {29'b0, slow_tick, slow_tick_gated, src_is_xtal}, 32'h0);
        rd(8'h00, 32'h0, "R1");
        rd(8'h08, 32'h0, "R1");
        rd(8'h60, 32'h0, "R1");

        // R3: busy flags and key field readback
        busy_in = 3'b101;
        rd(8'h00, 32'h0000_0280, "R3");
        cycle(1'b1, 8'h00, 32'h16AA_0381, 1'b0, 1'b0, "R3");
        rd(8'h00, 32'h0000_0281, "R3");
        busy_in = 3'b010;
        rd(8'h00, 32'h0000_0101, "R3");

        // R2: writes without the key are ignored
        cycle(1'b1, 8'h00, 32'h0000_0000, 1'b0, 1'b0, "R2");
        rd(8'h00, 32'h0000_0101, "R2");
        cycle(1'b1, 8'h00, 32'h16AB_0000, 1'b0, 1'b0, "R2");
        rd(8'h00, 32'h0000_0101, "R2");
        cycle(1'b1, 8'h00, 32'h16AA_0000, 1'b0, 1'b0, "R2");
        rd(8'h00, 32'h0000_0100, "R2");

        // R9: unmapped offsets
        cycle(1'b1, 8'h04, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9");
        cycle(1'b1, 8'h5C, 32'hFFFF_FFFF, 1'b0, 1'b0, "R9");
        rd(8'h04, 32'h0, "R9");
        rd(8'h5C, 32'h0, "R9");
        rd(8'h08, 32'h0, "R9");
        rd(8'h60, 32'h0, "R9");
        rd(8'h00, 32'h0000_0100, "R9");

        // R5: sweep every prescaler value on the RC path
        for (int p = 0; p < 32; p++) begin
            cycle(1'b1, 8'h08, 32'hFFFF_FFE0 | p, 1'b0, 1'b0, "R5");
            rd(8'h08, 32'(p), "R5");
            for (int i = 0; i < 2 * FIX * (p + 1) + 3; i++) begin
                cycle(1'b0, 8'h10, 32'h0, 1'b1, (i % 3) == 0, "R5");
                cycle(1'b0, 8'h10, 32'h0, 1'b0, 1'b1, "R5");
            end
        end

        // R6: open gate, R4: crystal path
        cycle(1'b1, 8'h60, 32'h0000_0001, 1'b0, 1'b0, "R6");
        rd(8'h60, 32'h1, "R6");
        cycle(1'b1, 8'h00, 32'h16AA_0001, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 64; i++)
            cycle(1'b0, 8'h10, 32'h0, i[0], ((i * 7) % 5) < 2, "R4");
        for (int i = 0; i < 8; i++)
            cycle(1'b0, 8'h10, 32'h0, 1'b1, 1'b1, "R4");

        // R7: divider clearing rules on the RC path, prescaler 2 (period 12)
        cycle(1'b1, 8'h08, 32'h0000_0002, 1'b0, 1'b0, "R7");
        cycle(1'b1, 8'h00, 32'h16AA_0000, 1'b1, 1'b0, "R7");
        idle_pulses(5, "R7");
        cycle(1'b1, 8'h08, 32'h0000_0002, 1'b1, 1'b0, "R7");
        idle_pulses(7, "R7");
        idle_pulses(5, "R7");
        cycle(1'b1, 8'h08, 32'h0000_0003, 1'b1, 1'b0, "R7");
        idle_pulses(17, "R7");
        idle_pulses(5, "R7");
        cycle(1'b1, 8'h00, 32'h16AA_0001, 1'b1, 1'b1, "R7");
        cycle(1'b0, 8'h10, 32'h0, 1'b0, 1'b1, "R7");
        cycle(1'b1, 8'h00, 32'h16AA_0000, 1'b1, 1'b1, "R7");
        idle_pulses(17, "R7");

        // R6: closing the gate silences the gated output
        cycle(1'b1, 8'h60, 32'h0000_0000, 1'b1, 1'b0, "R6");
        idle_pulses(20, "R6");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule